// File: doc/BRIEF.md
# Counter Read-Back Latch Port

This block is the host access side of a group of three 16-bit down-counters. The host moves one byte per access. It writes control words and count values, and it reads live counts, latched counts or a status byte. Address 3 takes control words. Addresses 0 to 2 are the data ports of the three counters. The `rdata` output shows, without delay, the byte that a read at the current address returns. The read's side effects (pointer advance, latch release) take place on the clock edge while `rd_en` is high. When `wr_en` and `rd_en` are both high, the write is performed and the read has no effect.

A control word whose top two bits are `11` is a read-back command. It can name any subset of the counters and can ask for the count, the status, or both. Each counter has its own count latch and its own status latch. A latch that holds a value the host has not yet read ignores every further request aimed at it. It gives up its value only once the host has read it completely. Any other control word programs one counter: its byte selection and its clock source. The clock source is either an internal prescaled tick, which stops while `pd` is high, or that counter's own `ext_clk` line, which is synchronised into the `clk` domain. The counters count down so that the latches have something to capture.

Top module: `ctr_readback_port`

## Requirements
- R1: Counter programming word (at address 3): bits [7:6] give the counter index (0 to 2), bits [5:4] give the byte selection (01 low only, 10 high only, 11 low then high), and bit 0 selects the external clock when set. A write with selection 01 loads {8'h00, byte}, and selection 10 loads {byte, 8'h00}. A read with selection 01 returns the low byte and a read with 10 returns the high byte.
- R2: With selection 11, the first data write only stages its byte. The live count is unchanged until the second write, which loads {second, first}. Reads return the low byte and then the high byte.
- R3: Read-back word: bits [7:6]=11, bit 5 requests the count, bit 4 requests the status, and bit i of [2:0] names counter i. One command latches every requested item of every named counter.
- R4: While a latch holds an unread value, a later request for that latch has no effect. Reads return the value from the earliest request, even after the live count has been reloaded.
- R5: The count latch and the status latch of a counter are independent. One command can fill one of them while the request for the other is ignored.
- R6: When a counter has a status value held, the next read of that counter returns the status byte. The count latch is left untouched by that read.
- R7: A count latch is released once all of its bytes under the programmed selection have been read. Later reads return the live count.
- R8: A programming word (selection not 00) clears both latches of its counter, resets the byte pointers and clears the new-count flag. A programming word with selection 00 has no effect.
- R9: The status byte is {ext select, new-count flag, selection[1:0], 4'b0000}, captured when the latch is taken. The flag is set by a completed count load and cleared by a decrement. After reset the status reads 8'h30.
- R10: A counter on the internal source decrements once every PRESCALE cycles while `pd` is low, and does not change while `pd` is high.
- R11: A counter on the external source decrements once for each rising edge of its `ext_clk` line, after a two-flop synchroniser, whatever the level of `pd`.
- R12: A decrement from 16'h0000 gives 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 2 | 0 to 2: counter data port, 3: control word |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Byte returned by a read at `addr` (0 for address 3) |
| pd | input | 1 | Powerdown: stops the internal tick |
| ext_clk | input | 3 | External clock, one line per counter |

## Verification
The assertions take for granted that a read and a write are never applied in the same cycle. They also assume that no read-back command arrives in the same cycle as a data read, because the single write path rules this out. Each `ext_clk` level is expected to last at least two `clk` cycles so that the synchroniser sees every edge. The random phase keeps `pd` high and every `ext_clk` line still, so no counter moves and the bench model of latches, pointers and status is exact. Counting is checked only in directed steps, where the exact number of ext pulses is known or, for the internal tick, within a window of one tick.

// File: rtl/ctr_readback_pkg.sv
package ctr_readback_pkg;
    localparam int NUM_CTR = 3;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2 * BYTE_W;

    typedef enum logic [1:0] {
        RW_NONE = 2'b00,
        RW_LO   = 2'b01,
        RW_HI   = 2'b10,
        RW_BOTH = 2'b11
    } rw_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  cnt_lat;
        logic [BYTE_W-1:0] sts_lat;
        logic [BYTE_W-1:0] stage;
        rw_sel_e           rw;
        logic              ext;
        logic              newcnt;
        logic              cnt_full;
        logic              sts_full;
        logic              wr_ptr;
        logic              rd_ptr;
    } chan_state_t;
endpackage

// File: rtl/ctr_readback_tick.sv
module ctr_readback_tick #(
    parameter int NUM      = 3,
    parameter int PRESCALE = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pd_i,
    input  logic [NUM-1:0] ext_clk_i,
    output logic           int_tick_o,
    output logic [NUM-1:0] ext_rise_o
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

    typedef struct packed {
        logic [PW-1:0]  pre;
        logic           tick;
        logic [NUM-1:0] s1;
        logic [NUM-1:0] s2;
        logic [NUM-1:0] prev;
        logic [NUM-1:0] rise;
    } tick_state_t;

    tick_state_t tk_d, tk_q;

    always_comb begin
        tk_d      = tk_q;
        tk_d.s1   = ext_clk_i;
        tk_d.s2   = tk_q.s1;
        tk_d.prev = tk_q.s2;
        tk_d.rise = tk_q.s2 & ~tk_q.prev;
        tk_d.tick = 1'b0;
        if (!pd_i) begin
            if (tk_q.pre == PRE_LAST) begin
                tk_d.pre  = '0;
                tk_d.tick = 1'b1;
            end else begin
                tk_d.pre = tk_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tk_q <= '0;
        else        tk_q <= tk_d;
    end

    assign int_tick_o = tk_q.tick;
    assign ext_rise_o = tk_q.rise;

    assert_pd_stops_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pd_i |=> !int_tick_o);
endmodule

// File: rtl/ctr_readback_chan.sv
module ctr_readback_chan
    import ctr_readback_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              ctl_wr_i,
    input  rw_sel_e           ctl_rw_i,
    input  logic              ctl_ext_i,
    input  logic              data_wr_i,
    input  logic              data_rd_i,
    input  logic [BYTE_W-1:0] wbyte_i,
    input  logic              rb_cnt_i,
    input  logic              rb_sts_i,
    output logic [BYTE_W-1:0] rbyte_o,
    output logic              ext_sel_o
);
    chan_state_t ch_d, ch_q;
    logic [CNT_W-1:0]  src;
    logic [BYTE_W-1:0] status;
    logic              load;

    always_comb begin
        ch_d   = ch_q;
        load   = 1'b0;
        status = {ch_q.ext, ch_q.newcnt, ch_q.rw, 4'b0000};
        src    = ch_q.cnt_full ? ch_q.cnt_lat : ch_q.count;

        if (ch_q.sts_full) begin
            rbyte_o = ch_q.sts_lat;
        end else begin
            case (ch_q.rw)
                RW_LO:   rbyte_o = src[BYTE_W-1:0];
                RW_HI:   rbyte_o = src[CNT_W-1:BYTE_W];
                default: rbyte_o = ch_q.rd_ptr ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
            endcase
        end

        if (ctl_wr_i) begin
            ch_d.rw       = ctl_rw_i;
            ch_d.ext      = ctl_ext_i;
            ch_d.cnt_full = 1'b0;
            ch_d.sts_full = 1'b0;
            ch_d.wr_ptr   = 1'b0;
            ch_d.rd_ptr   = 1'b0;
            ch_d.newcnt   = 1'b0;
        end else begin
            if (data_rd_i) begin
                if (ch_q.sts_full) begin
                    ch_d.sts_full = 1'b0;
                end else if (ch_q.rw == RW_BOTH && !ch_q.rd_ptr) begin
                    ch_d.rd_ptr = 1'b1;
                end else begin
                    ch_d.rd_ptr   = 1'b0;
                    ch_d.cnt_full = 1'b0;
                end
            end
            if (rb_sts_i && !ch_q.sts_full) begin
                ch_d.sts_full = 1'b1;
                ch_d.sts_lat  = status;
            end
            if (rb_cnt_i && !ch_q.cnt_full) begin
                ch_d.cnt_full = 1'b1;
                ch_d.cnt_lat  = ch_q.count;
            end
        end

        if (data_wr_i) begin
            case (ch_q.rw)
                RW_LO: begin
                    ch_d.count = {{BYTE_W{1'b0}}, wbyte_i};
                    load       = 1'b1;
                end
                RW_HI: begin
                    ch_d.count = {wbyte_i, {BYTE_W{1'b0}}};
                    load       = 1'b1;
                end
                default: begin
                    if (!ch_q.wr_ptr) begin
                        ch_d.stage  = wbyte_i;
                        ch_d.wr_ptr = 1'b1;
                    end else begin
                        ch_d.count  = {wbyte_i, ch_q.stage};
                        ch_d.wr_ptr = 1'b0;
                        load        = 1'b1;
                    end
                end
            endcase
            if (load) ch_d.newcnt = 1'b1;
        end

        if (!load && tick_i) begin
            ch_d.count  = ch_q.count - 1'b1;
            ch_d.newcnt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q    <= '0;
            ch_q.rw <= RW_BOTH;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign ext_sel_o = ch_q.ext;

    assert_sts_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.sts_full && !data_rd_i && !ctl_wr_i) |=> (ch_q.sts_full && $stable(ch_q.sts_lat)));

    assert_cnt_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.cnt_full && !data_rd_i && !ctl_wr_i) |=> (ch_q.cnt_full && $stable(ch_q.cnt_lat)));

    assert_status_read_keeps_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.sts_full && data_rd_i && !ctl_wr_i) |=> $stable(ch_q.cnt_full));

    assert_program_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_i |=> (!ch_q.cnt_full && !ch_q.sts_full && !ch_q.rd_ptr && !ch_q.wr_ptr));

    assert_count_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !data_wr_i) |=> $stable(ch_q.count));
endmodule

// File: rtl/ctr_readback_port.sv
module ctr_readback_port
    import ctr_readback_pkg::*;
#(
    parameter int PRESCALE = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [1:0]          addr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   rdata,
    input  logic                pd,
    input  logic [NUM_CTR-1:0]  ext_clk
);
    localparam logic [1:0] CTL_ADDR = 2'd3;
    localparam logic [1:0] RB_CODE  = 2'b11;

    logic [NUM_CTR-1:0] ctl_wr, data_wr, data_rd, rb_cnt, rb_sts, ext_sel, tick, ext_rise;
    logic [BYTE_W-1:0]  rbyte [NUM_CTR];
    logic               int_tick, is_ctl, is_rb;

    assign is_ctl = wr_en && (addr == CTL_ADDR);
    assign is_rb  = is_ctl && (wdata[7:6] == RB_CODE);

    always_comb begin
        for (int i = 0; i < NUM_CTR; i++) begin
            ctl_wr[i]  = is_ctl && !is_rb && (wdata[7:6] == 2'(i)) && (wdata[5:4] != 2'b00);
            data_wr[i] = wr_en && (addr == 2'(i));
            data_rd[i] = rd_en && !wr_en && (addr == 2'(i));
            rb_cnt[i]  = is_rb && wdata[5] && wdata[i];
            rb_sts[i]  = is_rb && wdata[4] && wdata[i];
        end
    end

    ctr_readback_tick #(.NUM(NUM_CTR), .PRESCALE(PRESCALE)) tick_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_i       (pd),
        .ext_clk_i  (ext_clk),
        .int_tick_o (int_tick),
        .ext_rise_o (ext_rise)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_chan
        assign tick[g] = ext_sel[g] ? ext_rise[g] : int_tick;

        ctr_readback_chan chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick[g]),
            .ctl_wr_i  (ctl_wr[g]),
            .ctl_rw_i  (rw_sel_e'(wdata[5:4])),
            .ctl_ext_i (wdata[0]),
            .data_wr_i (data_wr[g]),
            .data_rd_i (data_rd[g]),
            .wbyte_i   (wdata),
            .rb_cnt_i  (rb_cnt[g]),
            .rb_sts_i  (rb_sts[g]),
            .rbyte_o   (rbyte[g]),
            .ext_sel_o (ext_sel[g])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (addr == 2'(i)) rdata = rbyte[i];
        end
    end
endmodule

// File: tb/ctr_readback_port_tb_top.sv
module ctr_readback_port_tb_top;
    localparam int CLK_P    = 10;
    localparam int PRESCALE = 4;
    localparam int SEED     = 1234;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, pd = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [2:0] ext_clk = 3'b000;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    ctr_readback_port #(.PRESCALE(PRESCALE)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pd(pd), .ext_clk(ext_clk)
    );

    always #(CLK_P/2) clk = ~clk;

    // bench model of the host-visible state
    int          m_rw  [3];
    logic [15:0] m_cnt [3];
    logic [15:0] m_cl  [3];
    logic [7:0]  m_sl  [3];
    logic [7:0]  m_stg [3];
    bit m_wp[3], m_rp[3], m_cf[3], m_sf[3], m_ext[3], m_new[3];

    function automatic logic [7:0] m_status(int i);
        return {m_ext[i], m_new[i], 2'(m_rw[i]), 4'b0000};
    endfunction

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_ctl(int i, int rw, bit ext);
        bus_wr(2'd3, {2'(i), 2'(rw), 3'b000, ext});
        if (rw != 0) begin
            m_rw[i] = rw; m_ext[i] = ext; m_cf[i] = 0; m_sf[i] = 0;
            m_wp[i] = 0; m_rp[i] = 0; m_new[i] = 0;
        end
    endtask

    task automatic do_rb(logic [2:0] mask, bit c, bit s);
        bus_wr(2'd3, {2'b11, c, s, 1'b0, mask});
        for (int i = 0; i < 3; i++) begin
            if (mask[i]) begin
                if (c && !m_cf[i]) begin m_cl[i] = m_cnt[i]; m_cf[i] = 1; end
                if (s && !m_sf[i]) begin m_sl[i] = m_status(i); m_sf[i] = 1; end
            end
        end
    endtask

    task automatic do_wr(int i, logic [7:0] b);
        bus_wr(2'(i), b);
        case (m_rw[i])
            1: begin m_cnt[i] = {8'h00, b}; m_new[i] = 1; end
            2: begin m_cnt[i] = {b, 8'h00}; m_new[i] = 1; end
            default: begin
                if (!m_wp[i]) begin m_stg[i] = b; m_wp[i] = 1; end
                else begin m_cnt[i] = {b, m_stg[i]}; m_wp[i] = 0; m_new[i] = 1; end
            end
        endcase
    endtask

    task automatic do_rd(int i, string tag);
        logic [7:0]  exp, act;
        logic [15:0] src;
        if (m_sf[i]) begin
            exp = m_sl[i]; m_sf[i] = 0;
        end else begin
            src = m_cf[i] ? m_cl[i] : m_cnt[i];
            if (m_rw[i] == 1) begin exp = src[7:0]; m_cf[i] = 0; end
            else if (m_rw[i] == 2) begin exp = src[15:8]; m_cf[i] = 0; end
            else if (!m_rp[i]) begin exp = src[7:0]; m_rp[i] = 1; end
            else begin exp = src[15:8]; m_rp[i] = 0; m_cf[i] = 0; end
        end
        bus_rd(2'(i), act);
        check8(tag, act, exp);
    endtask

    task automatic ext_pulse(int i);
        ext_clk[i] = 1'b1;
        repeat (6) @(negedge clk);
        ext_clk[i] = 1'b0;
        repeat (6) @(negedge clk);
        m_cnt[i] = m_cnt[i] - 16'd1;
        m_new[i] = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [7:0]  lo, hi;
        logic [15:0] val;
        void'($urandom(SEED));
        for (int i = 0; i < 3; i++) begin
            m_rw[i] = 3; m_cnt[i] = 0; m_cl[i] = 0; m_sl[i] = 0; m_stg[i] = 0;
            m_wp[i] = 0; m_rp[i] = 0; m_cf[i] = 0; m_sf[i] = 0; m_ext[i] = 0; m_new[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state: status 8'h30, live count zero
        do_rb(3'b001, 0, 1);
        do_rd(0, "R9 reset status");
        do_rd(0, "R7 reset live lo");
        do_rd(0, "R7 reset live hi");

        // load three counters with two-byte writes
        for (int i = 0; i < 3; i++) do_ctl(i, 3, 0);
        do_wr(0, 8'h34); do_wr(0, 8'h12);
        do_wr(1, 8'h78); do_wr(1, 8'h56);
        do_wr(2, 8'hBC); do_wr(2, 8'h9A);

        // six-command sequence, C0 reloaded after the first command
        do_rb(3'b001, 1, 1);
        do_wr(0, 8'h21); do_wr(0, 8'h43);
        do_rb(3'b010, 0, 1);
        do_rb(3'b110, 0, 1);
        do_rb(3'b100, 1, 0);
        do_rb(3'b010, 1, 1);
        do_rb(3'b001, 1, 0);
        do_rd(0, "R6 status first");
        do_rd(0, "R4 first count lo");
        do_rd(0, "R4 first count hi");
        do_rd(0, "R7 live after release");
        do_rd(0, "R7 live hi");
        do_rd(1, "R5 status");
        do_rd(1, "R5 count lo");
        do_rd(1, "R5 count hi");
        do_rd(2, "R3 status");
        do_rd(2, "R3 count lo");
        do_rd(2, "R3 count hi");

        // single-byte selections
        do_ctl(1, 1, 0); do_wr(1, 8'hAA);
        do_rd(1, "R1 low only"); do_rd(1, "R1 low only again");
        do_ctl(1, 2, 0); do_wr(1, 8'h55);
        do_rd(1, "R1 high only");

        // staging of the first byte
        do_ctl(2, 3, 0); do_wr(2, 8'h11);
        do_rd(2, "R2 staged lo"); do_rd(2, "R2 staged hi");
        do_wr(2, 8'h22);
        do_rd(2, "R2 loaded lo"); do_rd(2, "R2 loaded hi");

        // programming clears latches; reserved selection ignored
        do_rb(3'b100, 1, 1); do_ctl(2, 3, 0);
        do_rd(2, "R8 latch cleared"); do_rd(2, "R8 latch cleared hi");
        do_ctl(0, 0, 1);
        do_rb(3'b001, 0, 1);
        do_rd(0, "R8 reserved ignored");

        // external clock and wrap
        do_ctl(1, 3, 1); do_wr(1, 8'h00); do_wr(1, 8'h00);
        ext_pulse(1);
        do_rd(1, "R12 wrap lo"); do_rd(1, "R12 wrap hi");
        ext_pulse(1);
        do_rb(3'b010, 0, 1);
        do_rd(1, "R9 status after tick");
        ext_pulse(1);
        do_rd(1, "R11 ext lo"); do_rd(1, "R11 ext hi");

        // internal prescaled clock and powerdown
        do_ctl(0, 3, 1);
        do_ctl(2, 3, 0); do_wr(2, 8'h00); do_wr(2, 8'h10);
        pd = 1'b0;
        repeat (40) @(negedge clk);
        pd = 1'b1;
        repeat (3) @(negedge clk);
        bus_rd(2'd2, lo); bus_rd(2'd2, hi);
        val = {hi, lo};
        checks++;
        if ((16'h1000 - val) < 16'd9 || (16'h1000 - val) > 16'd11) begin
            fails++;
            $display("FAIL R10 prescale: actual=%04h expected=%04h..%04h", val, 16'h0FF5, 16'h0FF7);
        end
        m_cnt[2] = val; m_new[2] = 0;
        repeat (20) @(negedge clk);
        do_rd(2, "R10 frozen lo"); do_rd(2, "R10 frozen hi");

        // random phase: counts frozen (pd high, ext lines still)
        for (int n = 0; n < 600; n++) begin
            int op, ch;
            op = $urandom % 10;
            ch = $urandom % 3;
            if (op == 0)      do_ctl(ch, $urandom % 4, 1'($urandom % 2));
            else if (op < 4)  do_wr(ch, 8'($urandom));
            else if (op < 6)  do_rb(3'($urandom), 1'($urandom % 2), 1'($urandom % 2));
            else              do_rd(ch, "R4 random");
        end

        summary();
    end
endmodule